// File: doc/BRIEF.md
# Serial Command Microport Controller

This block is a synchronous serial slave through which a microcontroller reads and writes the memories of a small time-slot switch. The host drives a serial clock, an active-low chip select and a receive line. The block answers on a transmit line that has its own output enable, so the host can tie the receive and transmit lines together. Every access opens with a falling edge on chip select. The first byte shifted in is a command byte that carries an operation code and a stream/channel address. It is followed by a data byte, which is shifted in for a write or shifted out for a read. Bits travel least significant first.

The three serial pins are asynchronous to the system clock and pass through two-flop synchronisers. Edges are detected in the system clock domain. For each completed command the block issues a one-cycle request to the switch core. The request carries the direction, the target memory, the connection/message flag, the address and the write data. For a read, the request goes out as soon as the command byte is complete. The core returns the byte on `rd_valid_i`/`rd_data_i`, and the block holds it until the first serial-clock falling edge shifts it out. Several writes may be chained under one chip select. A read always ends with chip select rising.

Top module: `cmdport_ctrl`

## Requirements
- R1: After reset the transmit enable `txd_oe_o` is low and `req_valid_o` is low.
- R2: The first byte after a chip-select falling edge is the command byte, sampled on serial-clock rising edges, LSB first. `req_addr_o` equals command bits 7:2: bit 7 is the stream and bits 6:2 are the channel (0 to 31).
- R3: Command bits 1:0 select the operation. Written as {bit1,bit0}: 00 reads the connect memory, 01 reads the data memory (`req_dmem_o`=1), 10 writes the connect memory in connection mode (`req_msg_o`=0), and 11 writes the connect memory in message mode (`req_msg_o`=1).
- R4: For a write, the next eight serial-clock rising edges shift in the data byte, LSB first. One write request with that byte on `req_wdata_o` follows the eighth edge.
- R5: For a read, a read request is issued when the command byte completes. The returned byte then leaves on `txd_o` LSB first, and each bit changes on one of the next eight serial-clock falling edges.
- R6: `txd_oe_o` is low except from the first falling edge of a read's data phase until chip select rises.
- R7: While chip select stays low, command/data byte pairs for writes may follow one another. Each pair produces its own write request.
- R8: While chip select is high, serial-clock and receive-line activity produce no request and no output. A chip-select rise in the middle of a byte discards the partial byte.
- R9: After the eighth bit of a read, further serial-clock edges produce no request, and `txd_o` holds the last bit until chip select rises.
- R10: `req_valid_o` is a single-cycle pulse per access.
- R11: With the default of two synchroniser stages, a serial-pin change first present at a system clock edge takes effect at the outputs after the third such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| csn_i | input | 1 | Active-low chip select (asynchronous) |
| rxd_i | input | 1 | Serial receive data (asynchronous) |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit driver enable; low means high impedance |
| req_valid_o | output | 1 | One-cycle memory request strobe |
| req_write_o | output | 1 | Request is a connect-memory write |
| req_dmem_o | output | 1 | Read request targets the data memory |
| req_msg_o | output | 1 | Write sets message mode (else connection mode) |
| req_addr_o | output | 6 | {stream, channel} address |
| req_wdata_o | output | 8 | Write data byte |
| rd_valid_i | input | 1 | Core returns read data this cycle |
| rd_data_i | input | 8 | Read data from the core |

## Verification
Two events can fall in the same system clock cycle. One is the eighth receive edge that completes a byte and pulses a request. The other is a chip-select rise that must close the access without a request. The bench provokes this by ending accesses right after the last bit, and mid-byte as well. A behavioural model in the bench delays the serial pins by the synchroniser latency and applies chip select first. It is compared with every output on every clock, so a request that slips through on the same cycle as the rise, or a transmit enable that lingers, shows up in the exact cycle.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

  // access sequencing phases
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_WDAT = 3'd2,
    PH_RD   = 3'd3,
    PH_HOLD = 3'd4
  } phase_e;

  // operation code, value = {bit1, bit0} of the command byte
  typedef enum logic [1:0] {
    OP_RD_CONN = 2'b00,
    OP_RD_DATA = 2'b01,
    OP_WR_CONN = 2'b10,
    OP_WR_MSG  = 2'b11
  } opcode_e;

  localparam int OP_W = 2;

endpackage

// File: rtl/cmdport_sync.sv
module cmdport_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cmdport_rx.sv
module cmdport_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] byte_next_o,
  output logic              done_o
);

  localparam int                CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // LSB arrives first, so new bits enter at the top
  assign byte_next_o = {bit_i, shreg_q[DATA_W-1:1]};
  assign done_o      = shift_i && (cnt_q == LAST_IDX);

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (shift_i) begin
      shreg_d = byte_next_o;
      cnt_d   = done_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: a cleared counter needs a full byte of shifts before completion
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !done_o);

endmodule

// File: rtl/cmdport_tx.sv
module cmdport_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              release_i,
  output logic              txd_o,
  output logic              oe_o,
  output logic              last_o
);

  localparam int               IDX_W    = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] data_q, data_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              txd_q, txd_d;
  logic              oe_q, oe_d;

  assign last_o = shift_i && (idx_q == LAST_IDX);

  always_comb begin
    data_d = data_q;
    idx_d  = idx_q;
    txd_d  = txd_q;
    oe_d   = oe_q;
    if (release_i) begin
      oe_d = 1'b0;
    end else begin
      if (load_i) begin
        data_d = data_i;
        idx_d  = '0;
      end
      if (shift_i) begin
        txd_d = data_q[idx_q];
        oe_d  = 1'b1;
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      idx_q  <= '0;
      txd_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      idx_q  <= idx_d;
      txd_q  <= txd_d;
      oe_q   <= oe_d;
    end
  end

  assign txd_o = txd_q;
  assign oe_o  = oe_q;

  // R5
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q) && !$past(shift_i)) |-> $stable(txd_q));

  // R6
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(shift_i));

endmodule

// File: rtl/cmdport_ctrl.sv
module cmdport_ctrl
  import cmdport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck_i,
  input  logic                   csn_i,
  input  logic                   rxd_i,
  output logic                   txd_o,
  output logic                   txd_oe_o,
  output logic                   req_valid_o,
  output logic                   req_write_o,
  output logic                   req_dmem_o,
  output logic                   req_msg_o,
  output logic [DATA_W-OP_W-1:0] req_addr_o,
  output logic [DATA_W-1:0]      req_wdata_o,
  input  logic                   rd_valid_i,
  input  logic [DATA_W-1:0]      rd_data_i
);

  localparam int ADDR_W = DATA_W - OP_W;
  localparam int PIN_W  = 3;
  localparam int B_SCK  = 0;
  localparam int B_CSN  = 1;
  localparam int B_RXD  = 2;

  // ---------------- synchronisers and edge detection ----------------
  logic [PIN_W-1:0] pins_s;
  logic [1:0]       edge_q;

  cmdport_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({PIN_W{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({rxd_i, csn_i, sck_i}),
    .sync_o  (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 2'b11;
    else        edge_q <= pins_s[B_CSN:B_SCK];
  end

  logic sck_rise, sck_fall, cs_rise, cs_fall, rxd_s;
  assign sck_rise = pins_s[B_SCK] & ~edge_q[B_SCK];
  assign sck_fall = ~pins_s[B_SCK] & edge_q[B_SCK];
  assign cs_rise  = pins_s[B_CSN] & ~edge_q[B_CSN];
  assign cs_fall  = ~pins_s[B_CSN] & edge_q[B_CSN];
  assign rxd_s    = pins_s[B_RXD];

  // ---------------- phase register ----------------
  phase_e phase_q, phase_d;

  logic rx_shift, tx_shift;
  logic rx_done, tx_last;
  logic [DATA_W-1:0] rx_byte;

  assign rx_shift = sck_rise && !cs_rise && !cs_fall &&
                    (phase_q == PH_CMD || phase_q == PH_WDAT);
  assign tx_shift = sck_fall && !cs_rise && !cs_fall && (phase_q == PH_RD);

  cmdport_rx #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (cs_fall),
    .shift_i     (rx_shift),
    .bit_i       (rxd_s),
    .byte_next_o (rx_byte),
    .done_o      (rx_done)
  );

  cmdport_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (rd_valid_i),
    .data_i    (rd_data_i),
    .shift_i   (tx_shift),
    .release_i (cs_rise),
    .txd_o     (txd_o),
    .oe_o      (txd_oe_o),
    .last_o    (tx_last)
  );

  // ---------------- command decode ----------------
  opcode_e           op_new;
  logic              op_is_write;
  logic [ADDR_W-1:0] addr_new;

  assign op_new      = opcode_e'(rx_byte[OP_W-1:0]);
  assign op_is_write = (op_new == OP_WR_CONN) || (op_new == OP_WR_MSG);
  assign addr_new    = rx_byte[DATA_W-1:OP_W];

  // pending write target, held across the data byte
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic              pend_msg_q, pend_msg_d;

  // request registers
  logic              req_v_q, req_v_d;
  logic              req_w_q, req_w_d;
  logic              req_dm_q, req_dm_d;
  logic              req_msg_q, req_msg_d;
  logic [ADDR_W-1:0] req_addr_q, req_addr_d;
  logic [DATA_W-1:0] req_wdata_q, req_wdata_d;

  always_comb begin
    phase_d     = phase_q;
    pend_addr_d = pend_addr_q;
    pend_msg_d  = pend_msg_q;
    req_v_d     = 1'b0;
    req_w_d     = req_w_q;
    req_dm_d    = req_dm_q;
    req_msg_d   = req_msg_q;
    req_addr_d  = req_addr_q;
    req_wdata_d = req_wdata_q;

    if (cs_rise) begin
      phase_d = PH_IDLE;
    end else if (cs_fall) begin
      phase_d = PH_CMD;
    end else begin
      unique case (phase_q)
        PH_CMD: begin
          if (rx_done) begin
            if (op_is_write) begin
              pend_addr_d = addr_new;
              pend_msg_d  = (op_new == OP_WR_MSG);
              phase_d     = PH_WDAT;
            end else begin
              req_v_d    = 1'b1;
              req_w_d    = 1'b0;
              req_dm_d   = (op_new == OP_RD_DATA);
              req_msg_d  = 1'b0;
              req_addr_d = addr_new;
              phase_d    = PH_RD;
            end
          end
        end
        PH_WDAT: begin
          if (rx_done) begin
            req_v_d     = 1'b1;
            req_w_d     = 1'b1;
            req_dm_d    = 1'b0;
            req_msg_d   = pend_msg_q;
            req_addr_d  = pend_addr_q;
            req_wdata_d = rx_byte;
            phase_d     = PH_CMD;
          end
        end
        PH_RD: begin
          if (tx_last) phase_d = PH_HOLD;
        end
        PH_HOLD: phase_d = PH_HOLD;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      pend_addr_q <= '0;
      pend_msg_q  <= 1'b0;
      req_v_q     <= 1'b0;
      req_w_q     <= 1'b0;
      req_dm_q    <= 1'b0;
      req_msg_q   <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else begin
      phase_q     <= phase_d;
      pend_addr_q <= pend_addr_d;
      pend_msg_q  <= pend_msg_d;
      req_v_q     <= req_v_d;
      req_w_q     <= req_w_d;
      req_dm_q    <= req_dm_d;
      req_msg_q   <= req_msg_d;
      req_addr_q  <= req_addr_d;
      req_wdata_q <= req_wdata_d;
    end
  end

  assign req_valid_o = req_v_q;
  assign req_write_o = req_w_q;
  assign req_dmem_o  = req_dm_q;
  assign req_msg_o   = req_msg_q;
  assign req_addr_o  = req_addr_q;
  assign req_wdata_o = req_wdata_q;

  // ---------------- assertions ----------------
  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> !$past(pins_s[B_CSN]));

  // R4
  wr_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_write_o) |-> ($past(phase_q) == PH_WDAT));

  // R6
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe_o |-> (phase_q == PH_RD || phase_q == PH_HOLD));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD) |-> !req_valid_o);

endmodule

// File: tb/cmdport_ctrl_bench.sv
module cmdport_ctrl_bench;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sck = 1'b1, csn = 1'b1, rxd = 1'b1;
  logic rd_valid = 1'b0;
  logic [7:0] rd_data = 8'h00;

  logic       txd_o, txd_oe_o, req_valid_o, req_write_o, req_dmem_o, req_msg_o;
  logic [5:0] req_addr_o;
  logic [7:0] req_wdata_o;

  cmdport_ctrl u_cmdport_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .rxd_i(rxd),
    .txd_o(txd_o), .txd_oe_o(txd_oe_o), .req_valid_o(req_valid_o),
    .req_write_o(req_write_o), .req_dmem_o(req_dmem_o), .req_msg_o(req_msg_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // switch-core stand-in memories
  logic [7:0] cm [64];
  logic       cm_msg [64];
  logic [7:0] dm [64];
  int wr_count = 0, rd_count = 0, double_req = 0;
  int cyc = 0, last_req_cyc = 0;
  bit prev_req = 0;

  // ---------------- behavioural reference ----------------
  logic [2:0] h0, h1, h2;   // {rxd,csn,sck} sampled at past edges
  int   ph;                 // 0 idle,1 cmd,2 wdata,3 read,4 hold
  int   nb, nfall;
  logic [7:0] sr, cmdb, txbyte;
  logic m_oe, m_txd, m_rv, m_rw, m_rdm, m_rmsg;
  logic [5:0] m_addr;
  logic [7:0] m_wdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 = 3'b111; h1 = 3'b111; h2 = 3'b111;
      ph = 0; nb = 0; nfall = 0; sr = 0; cmdb = 0; txbyte = 0;
      m_oe = 0; m_txd = 0; m_rv = 0; m_rw = 0; m_rdm = 0; m_rmsg = 0;
      m_addr = 0; m_wdata = 0;
    end else begin
      logic [2:0] cur, old;
      cyc++;
      cur = h1; old = h2;
      m_rv = 0;
      if (cur[1] && !old[1]) begin
        ph = 0; m_oe = 0;
      end else if (!cur[1] && old[1]) begin
        ph = 1; nb = 0;
      end else if ((ph == 1 || ph == 2) && cur[0] && !old[0]) begin
        sr = {cur[2], sr[7:1]};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (ph == 1) begin
            cmdb = sr;
            if (sr[1]) ph = 2;
            else begin
              ph = 3; nfall = 0;
              m_rv = 1; m_rw = 0; m_rdm = sr[0]; m_rmsg = 0; m_addr = sr[7:2];
              txbyte = sr[0] ? dm[sr[7:2]] : cm[sr[7:2]];
            end
          end else begin
            m_rv = 1; m_rw = 1; m_rdm = 0; m_rmsg = cmdb[0];
            m_addr = cmdb[7:2]; m_wdata = sr; ph = 1;
          end
        end
      end else if (ph == 3 && !cur[0] && old[0]) begin
        m_oe = 1; m_txd = txbyte[nfall];
        nfall++;
        if (nfall == 8) ph = 4;
      end
      h2 = h1; h1 = h0; h0 = {rxd, csn, sck};
    end
  end

  // per-clock comparison and core response, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(txd_oe_o == m_oe, "R6/R11 txd_oe", txd_oe_o, m_oe);
      if (m_oe) check(txd_o == m_txd, "R5/R11 txd", txd_o, m_txd);
      check(req_valid_o == m_rv, "R10/R11 req_valid", req_valid_o, m_rv);
      if (m_rv && req_valid_o) begin
        check(req_write_o == m_rw, "R3 req_write", req_write_o, m_rw);
        check(req_addr_o == m_addr, "R2 req_addr", req_addr_o, m_addr);
        if (m_rw) begin
          check(req_msg_o == m_rmsg, "R3 req_msg", req_msg_o, m_rmsg);
          check(req_wdata_o == m_wdata, "R4 req_wdata", req_wdata_o, m_wdata);
        end else begin
          check(req_dmem_o == m_rdm, "R3 req_dmem", req_dmem_o, m_rdm);
        end
      end
      if (req_valid_o && prev_req) double_req++;
      prev_req = req_valid_o;
      rd_valid = 1'b0;
      if (req_valid_o) begin
        last_req_cyc = cyc;
        if (req_write_o) begin
          cm[req_addr_o] = req_wdata_o;
          cm_msg[req_addr_o] = req_msg_o;
          wr_count++;
        end else begin
          rd_valid = 1'b1;
          rd_data  = req_dmem_o ? dm[req_addr_o] : cm[req_addr_o];
          rd_count++;
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  localparam logic [1:0] OPC_RDC = 2'b00, OPC_RDD = 2'b01,
                         OPC_WRC = 2'b10, OPC_MSG = 2'b11;

  function automatic logic [7:0] mk_cmd(bit s, int ch, logic [1:0] op);
    return {s, ch[4:0], op};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    csn = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  int last_rise_cyc = 0;

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; rxd = b[i];
      wait_clk(HALF);
      sck = 1'b1; last_rise_cyc = cyc;
      wait_clk(HALF);
    end
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit oe_all);
    oe_all = 1;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0;
      wait_clk(HALF);
      b[i] = txd_o;
      if (!txd_oe_o) oe_all = 0;
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    bit oe_all;
    int w0, r0;
    for (int i = 0; i < 64; i++) begin
      cm[i] = 8'h00; cm_msg[i] = 1'b0; dm[i] = 8'(i * 37 + 5);
    end
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check(txd_oe_o == 1'b0, "R1 oe after reset", txd_oe_o, 0);
    check(req_valid_o == 1'b0, "R1 req after reset", req_valid_o, 0);

    // single connection-mode write, stream 0 channel 3
    cs_low();
    send_bits(mk_cmd(0, 3, OPC_WRC), 8);
    send_bits(8'hA5, 8);
    check(last_req_cyc - last_rise_cyc == 3, "R11 latency", last_req_cyc - last_rise_cyc, 3);
    cs_high();
    check(cm[3] == 8'hA5, "R4 write data", cm[3], 8'hA5);
    check(cm_msg[3] == 1'b0, "R3 connection mode", cm_msg[3], 0);
    check(wr_count == 1, "R4 one write", wr_count, 1);

    // chained writes, message mode then connection mode
    cs_low();
    send_bits(mk_cmd(1, 31, OPC_MSG), 8);
    send_bits(8'h3C, 8);
    send_bits(mk_cmd(0, 0, OPC_WRC), 8);
    send_bits(8'h81, 8);
    cs_high();
    check(cm[63] == 8'h3C, "R2 stream1 ch31 addr", cm[63], 8'h3C);
    check(cm_msg[63] == 1'b1, "R3 message mode", cm_msg[63], 1);
    check(cm[0] == 8'h81, "R7 second chained write", cm[0], 8'h81);
    check(wr_count == 3, "R7 chained count", wr_count, 3);

    // read connect memory 63, then extra clocks in hold
    cs_low();
    send_bits(mk_cmd(1, 31, OPC_RDC), 8);
    check(txd_oe_o == 1'b0, "R6 oe low before data", txd_oe_o, 0);
    check(rd_count == 1, "R5 read request at command end", rd_count, 1);
    recv_byte(got, oe_all);
    check(got == 8'h3C, "R5 read connect data", got, 8'h3C);
    check(oe_all, "R6 oe during read", oe_all, 1);
    w0 = wr_count; r0 = rd_count;
    send_bits(8'hFF, 3);
    check(txd_o == 1'b0, "R9 last bit held", txd_o, 0);
    check(wr_count == w0 && rd_count == r0, "R9 no request in hold", wr_count + rd_count, w0 + r0);
    cs_high();
    check(txd_oe_o == 1'b0, "R6 oe released", txd_oe_o, 0);

    // read data memory stream 0 channel 21
    cs_low();
    send_bits(mk_cmd(0, 21, OPC_RDD), 8);
    recv_byte(got, oe_all);
    cs_high();
    check(got == dm[21], "R3 read data memory", got, dm[21]);

    // activity with chip select high
    w0 = wr_count; r0 = rd_count;
    send_bits(mk_cmd(0, 5, OPC_WRC), 8);
    send_bits(8'h5A, 8);
    check(wr_count == w0 && rd_count == r0, "R8 cs high ignored", wr_count + rd_count, w0 + r0);
    check(txd_oe_o == 1'b0, "R8 oe with cs high", txd_oe_o, 0);

    // abort mid-byte, then a clean write
    cs_low();
    send_bits(mk_cmd(0, 9, OPC_MSG), 8);
    send_bits(8'hEE, 5);
    cs_high();
    check(wr_count == w0, "R8 partial byte discarded", wr_count, w0);
    cs_low();
    send_bits(mk_cmd(0, 9, OPC_WRC), 8);
    send_bits(8'h42, 8);
    cs_high();
    check(cm[9] == 8'h42 && cm_msg[9] == 1'b0, "R8 access after abort", cm[9], 8'h42);

    check(double_req == 0, "R10 single-cycle strobe", double_req, 0);
    wait_clk(20);
    finish_run();
  end

endmodule